// File: doc/BRIEF.md
# Instruction Line Predecoder

This block marks instruction boundaries inside an instruction cache line while the line is being filled after a miss. Fill data arrives as a stream of 16-bit parcels. For every accepted parcel the block decides whether an instruction begins there, reports that decision on a marker output, and collects the decisions for the line. When the last parcel of the line has been accepted, the collected markers are written into a per-line marker array along with a valid bit.

The decision uses only a 2-bit length field in the first parcel of each instruction, so an instruction is one, two or three parcels long. A small counter holds the number of parcels still owed to the current instruction. The first parcel of every line is taken to begin an instruction. An instruction that runs past the end of the line produces no further starts in that line.

A separate read port returns the stored markers for a line one cycle after the line index is presented. The hit path therefore finds instruction starts without decoding any lengths. The fill input is a valid/ready stream. Ready is high whenever the block is out of reset and never drops for back-pressure, so a parcel is accepted on every cycle in which valid and ready are both high. Valid may fall between parcels at any point.

Top module: `icache_predecode`

## Requirements
- R1: `fill_ready` is low while `rst_n` is low and high otherwise. A parcel is accepted on a rising clock edge where `fill_valid` and `fill_ready` are both high.
- R2: The length field is bits [15:14] of the parcel that begins an instruction. 00 means 1 parcel, 01 and 10 both mean 2 parcels, and 11 means 3 parcels. The field of any other parcel is ignored.
- R3: The first parcel (position 0) of every line is always marked as a start.
- R4: Any other parcel is marked as a start exactly when the parcels of the previous instruction have all been accepted. The cycle after each acceptance shows `mark_valid`=1, `mark_start` holding the decision and `mark_pos` holding the parcel position 0..7.
- R5: An instruction that extends past the eighth parcel marks no later parcel of that line. The next line starts fresh at position 0.
- R6: A cycle with no acceptance gives `mark_valid`=0 in the following cycle and does not advance the parcel position.
- R7: When the eighth parcel is accepted, the line's markers (bit i = parcel i) are stored at the `fill_index` presented with parcel 0, and the line is marked valid. `line_wr` is high in the same cycle as that parcel's marker output.
- R8: `rd_line_valid` and `rd_markers` show the line addressed by `rd_index` at the previous rising edge. A read on the same edge as a write to that line returns the old contents.
- R9: Reset clears every stored marker and valid bit, and it clears the fill position and counter. A line that has never been filled reads as invalid with all markers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_valid | input | 1 | A fill parcel is offered |
| fill_ready | output | 1 | The block can accept a parcel |
| fill_parcel | input | 16 | Fill parcel data |
| fill_index | input | 4 | Line being filled, sampled with parcel 0 |
| mark_valid | output | 1 | A marker for an accepted parcel is shown |
| mark_start | output | 1 | The parcel begins an instruction |
| mark_pos | output | 3 | Position of the parcel within the line |
| line_wr | output | 1 | The line's markers were written on this parcel |
| rd_index | input | 4 | Line to read from the marker array |
| rd_line_valid | output | 1 | The addressed line holds markers |
| rd_markers | output | 8 | Stored markers, bit i for parcel i |

## Verification
The bench sweeps every sequence of the three length classes over a line's eight positions, so it covers every way an instruction can straddle the line end. A design that carried the counter across lines, or that kept marking starts after an overrun, would show a wrong marker at position 0 or at the tail. The bench switches between the 01 and 10 codes, so a decoder that treats either of them as one or three parcels yields misplaced starts. Idle gaps in the middle of a line would expose a position counter that advances without an acceptance. Reads on the write edge would expose a store that forwards new data instead of returning the old contents. A reset in the middle of a fill would expose state that survives reset.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

  // Parcels still owed after the first one of an instruction.
  typedef logic [1:0] owed_t;

  // Length class from the 2-bit field: 00 -> 1, 01/10 -> 2, 11 -> 3 parcels.
  function automatic owed_t owed_from_code(input logic [1:0] code);
    owed_t r;
    unique case (code)
      2'b00:          r = 2'd0;
      2'b01, 2'b10:   r = 2'd1;
      default:        r = 2'd2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipd_len_decode.sv
module ipd_len_decode
  import ipd_pkg::*;
(
  input  logic [1:0] len_code,
  output owed_t      owed
);
  assign owed = owed_from_code(len_code);
endmodule

// File: rtl/ipd_marker_gen.sv
module ipd_marker_gen
  import ipd_pkg::*;
#(
  parameter int LINE_PARCELS = 8,
  parameter int IDX_W        = 4,
  localparam int POS_W       = $clog2(LINE_PARCELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [1:0]              len_code,
  input  logic [IDX_W-1:0]        index,
  output logic                    mark_valid,
  output logic                    mark_start,
  output logic [POS_W-1:0]        mark_pos,
  output logic                    line_wr,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_index,
  output logic [LINE_PARCELS-1:0] wr_markers
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_PARCELS - 1);

  owed_t                   owed_left;
  owed_t                   owed_new;
  logic [POS_W-1:0]        pos;
  logic [LINE_PARCELS-1:0] bits_so_far;
  logic [IDX_W-1:0]        line_idx;
  logic                    begins_here;
  logic                    at_last;

  ipd_len_decode u_dec (
    .len_code (len_code),
    .owed     (owed_new)
  );

  assign begins_here = (owed_left == 2'd0);
  assign at_last     = (pos == LAST_POS);

  assign wr_en      = accept && at_last;
  assign wr_index   = (pos == '0) ? index : line_idx;
  assign wr_markers = bits_so_far | (LINE_PARCELS'(begins_here) << pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_left   <= 2'd0;
      pos         <= '0;
      bits_so_far <= '0;
      line_idx    <= '0;
      mark_valid  <= 1'b0;
      mark_start  <= 1'b0;
      mark_pos    <= '0;
      line_wr     <= 1'b0;
    end else begin
      mark_valid <= accept;
      line_wr    <= accept && at_last;
      if (accept) begin
        mark_start <= begins_here;
        mark_pos   <= pos;
        if (pos == '0) line_idx <= index;
        if (at_last) begin
          pos         <= '0;
          owed_left   <= 2'd0;
          bits_so_far <= '0;
        end else begin
          pos              <= pos + POS_W'(1);
          owed_left        <= begins_here ? owed_new : owed_left - 2'd1;
          bits_so_far[pos] <= begins_here;
        end
      end
    end
  end

  AST_POS0_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_valid && mark_pos == '0) |-> mark_start); // R3

  AST_OWED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    owed_left != 2'd3); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!mark_valid && $stable(pos))); // R6

  AST_LINE_END_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_last) |=> (pos == '0 && owed_left == 2'd0)); // R5

endmodule

// File: rtl/ipd_marker_store.sv
module ipd_marker_store #(
  parameter int LINE_PARCELS = 8,
  parameter int NUM_LINES    = 16,
  localparam int IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_index,
  input  logic [LINE_PARCELS-1:0] wr_markers,
  input  logic [IDX_W-1:0]        rd_index,
  output logic                    rd_line_valid,
  output logic [LINE_PARCELS-1:0] rd_markers
);

  logic [LINE_PARCELS-1:0] marks [NUM_LINES];
  logic [NUM_LINES-1:0]    line_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) marks[i] <= '0;
      line_ok       <= '0;
      rd_line_valid <= 1'b0;
      rd_markers    <= '0;
    end else begin
      rd_line_valid <= line_ok[rd_index];
      rd_markers    <= marks[rd_index];
      if (wr_en) begin
        marks[wr_index]   <= wr_markers;
        line_ok[wr_index] <= 1'b1;
      end
    end
  end

  AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_line_valid |-> (rd_markers == '0)); // R9

  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> line_ok[$past(wr_index)]); // R7

endmodule

// File: rtl/icache_predecode.sv
module icache_predecode #(
  parameter int PARCEL_W     = 16,
  parameter int LINE_PARCELS = 8,
  parameter int NUM_LINES    = 16,
  localparam int IDX_W       = $clog2(NUM_LINES),
  localparam int POS_W       = $clog2(LINE_PARCELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [PARCEL_W-1:0]     fill_parcel,
  input  logic [IDX_W-1:0]        fill_index,
  output logic                    mark_valid,
  output logic                    mark_start,
  output logic [POS_W-1:0]        mark_pos,
  output logic                    line_wr,
  input  logic [IDX_W-1:0]        rd_index,
  output logic                    rd_line_valid,
  output logic [LINE_PARCELS-1:0] rd_markers
);

  logic                    accept;
  logic                    wr_en;
  logic [IDX_W-1:0]        wr_index;
  logic [LINE_PARCELS-1:0] wr_markers;
  logic                    unused_low_bits;

  assign fill_ready      = rst_n;
  assign accept          = fill_valid && fill_ready;
  assign unused_low_bits = ^fill_parcel[PARCEL_W-3:0];

  ipd_marker_gen #(
    .LINE_PARCELS (LINE_PARCELS),
    .IDX_W        (IDX_W)
  ) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .len_code   (fill_parcel[PARCEL_W-1 -: 2]),
    .index      (fill_index),
    .mark_valid (mark_valid),
    .mark_start (mark_start),
    .mark_pos   (mark_pos),
    .line_wr    (line_wr),
    .wr_en      (wr_en),
    .wr_index   (wr_index),
    .wr_markers (wr_markers)
  );

  ipd_marker_store #(
    .LINE_PARCELS (LINE_PARCELS),
    .NUM_LINES    (NUM_LINES)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_index      (wr_index),
    .wr_markers    (wr_markers),
    .rd_index      (rd_index),
    .rd_line_valid (rd_line_valid),
    .rd_markers    (rd_markers)
  );

  AST_FIRST_MARK_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_markers[0]); // R3

endmodule

// File: tb/tb_icache_predecode.sv
module tb_icache_predecode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [15:0] fill_parcel = '0;
  logic [3:0]  fill_index = '0;
  logic        mark_valid, mark_start, line_wr;
  logic [2:0]  mark_pos;
  logic [3:0]  rd_index = '0;
  logic        rd_line_valid;
  logic [7:0]  rd_markers;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  logic [7:0] exp_mem [16];
  bit         exp_vld [16];

  always #5 clk = ~clk;

  icache_predecode dut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_parcel(fill_parcel), .fill_index(fill_index), .mark_valid(mark_valid),
    .mark_start(mark_start), .mark_pos(mark_pos), .line_wr(line_wr),
    .rd_index(rd_index), .rd_line_valid(rd_line_valid), .rd_markers(rd_markers)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Sends one parcel; checks the marker one edge later.
  task automatic send(input logic [15:0] d, input logic [3:0] idx,
                      input int pos, input bit exp_start, input bit last);
    @(negedge clk);
    fill_valid = 1'b1; fill_parcel = d; fill_index = idx; rd_index = idx;
    @(posedge clk); #1;
    chk(mark_valid && mark_start == exp_start && mark_pos == 3'(pos) &&
        line_wr == last,
        (pos == 0) ? "R3 parcel 0 marker" : "R2 R4 parcel marker",
        {mark_valid, mark_start, line_wr, 1'b0, 1'(0), mark_pos},
        {1'b1, exp_start, last, 1'b0, 1'(0), 3'(pos)});
    if (last)
      chk(rd_line_valid == exp_vld[idx] && rd_markers == exp_mem[idx],
          "R8 read on write edge returns old", {rd_line_valid, rd_markers},
          {exp_vld[idx], exp_mem[idx]});
  endtask

  task automatic idle_chk();
    @(negedge clk);
    fill_valid = 1'b0;
    @(posedge clk); #1;
    chk(!mark_valid && !line_wr, "R6 idle gives no marker",
        {mark_valid, line_wr}, 0);
  endtask

  task automatic read_chk(input logic [3:0] idx, input string req);
    @(negedge clk);
    fill_valid = 1'b0; rd_index = idx;
    @(posedge clk); #1;
    chk(rd_line_valid == exp_vld[idx] && rd_markers == exp_mem[idx], req,
        {rd_line_valid, rd_markers}, {exp_vld[idx], exp_mem[idx]});
  endtask

  // Fills one line from 8 length classes; expected markers from R2..R5.
  task automatic fill_line(input int cls [8], input logic [3:0] idx,
                           input int seed, input int gap_at);
    int owed = 0;
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] code;
      bit st;
      code = (cls[i] == 0) ? 2'b00 : (cls[i] == 2) ? 2'b11 :
             (((seed + i) % 2) != 0 ? 2'b10 : 2'b01);
      st = (owed == 0);
      if (st) owed = cls[i]; else owed = owed - 1;
      m[i] = st;
      if (i == gap_at) idle_chk();
      send({code, 14'(seed * 7 + i * 3)}, idx, i, st, i == 7);
    end
    exp_mem[idx] = m;
    exp_vld[idx] = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin exp_mem[i] = '0; exp_vld[i] = 1'b0; end
    repeat (3) @(posedge clk); #1;
    chk(!fill_ready, "R1 ready low in reset", fill_ready, 0);
    chk(!mark_valid && !line_wr, "R9 reset outputs", {mark_valid, line_wr}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(fill_ready, "R1 ready high out of reset", fill_ready, 1);
    for (int i = 0; i < 16; i++) read_chk(4'(i), "R9 unfilled line invalid");

    // Sweep every class sequence (3^8); some lines get an idle gap.
    for (int n = 0; n < 6561; n++) begin
      int cls [8];
      int v = n;
      for (int i = 0; i < 8; i++) begin cls[i] = v % 3; v = v / 3; end
      fill_line(cls, 4'(n % 16), n, (n % 7 == 3) ? 1 + (n % 6) : -1);
      read_chk(4'(n % 16), "R7 R5 stored markers");
    end

    // Reset in the middle of a fill.
    begin
      int cls3 [8] = '{2, 2, 2, 2, 2, 2, 2, 2};
      send({2'b11, 14'd1}, 4'd5, 0, 1'b1, 1'b0);
      send({2'b00, 14'd2}, 4'd5, 1, 1'b0, 1'b0);
      @(negedge clk); fill_valid = 1'b0; rst_n = 1'b0;
      @(posedge clk); #1;
      chk(!fill_ready, "R1 ready low in second reset", fill_ready, 0);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin exp_mem[i] = '0; exp_vld[i] = 1'b0; end
      read_chk(4'd5, "R9 markers cleared by reset");
      read_chk(4'd0, "R9 valid cleared by reset");
      fill_line(cls3, 4'd9, 1, -1);
      read_chk(4'd9, "R9 R5 fresh fill after reset");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule